// File: doc/BRIEF.md
# DRAM Bank Row-Access Sequencer

This block turns read and write requests for one DRAM bank into the command stream the bank needs. Each request carries a row address and a column address. The sequencer sends them as separate commands over one shared address bus: first the row, then the column. It also remembers which row is currently open in the bank.

A request that targets the open row becomes a single column command. A run of such requests leaves the sequencer as one column command per cycle, as a burst. A request for a different row makes the sequencer close the open row with a precharge, wait, open the new row with an activate, wait again, and then send the column command. The wait lengths are parameters counted in clock cycles. For a read, the sequencer pulses a response valid signal after the read-latency count and passes the bank's returned data through in that cycle.

Top module: `bank_seq`

## Requirements
- R1: After reset the command output is idle (code 0), `cmd_addr` is 0, `req_ready` is 1, `rsp_valid` is 0, no row is open and the bank counts as precharged.
- R2: A request accepted while no row is open produces an activate (code 1) carrying the row in the cycle after acceptance. The column command follows exactly T_RCD cycles after the activate.
- R3: A request accepted while its row is open produces its column command (read code 2, write code 3) in the cycle after acceptance, with no activate or precharge. `req_ready` stays high, so requests accepted on consecutive cycles yield column commands on consecutive cycles.
- R4: A request accepted while a different row is open produces a precharge (code 4) in the cycle after acceptance. An activate for the new row follows exactly T_RP cycles after the precharge, and the column command follows exactly T_RCD cycles after that activate. An activate is never issued while a row is open.
- R5: On an activate, `cmd_addr` carries the row address. On a column command it carries the column address, zero-extended. On a precharge or idle cycle it is 0.
- R6: `rsp_valid` pulses for one cycle exactly T_CL cycles after each read command, with `rsp_data` equal to `dq_in` in that cycle. A write produces no pulse, and `rsp_data` is 0 whenever `rsp_valid` is low.
- R7: A write command presents the request's write data on `cmd_wdata`. The field is 0 on every other command.
- R8: While a precharge or activate wait is in progress, `req_ready` is 0 and no column command is issued. A request held during the wait is accepted in the cycle after the pending column command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_wdata | input | DATA_W | Write data |
| cmd | output | 3 | Bank command: 0 idle, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_addr | output | ADDR_W | Shared row/column address bus |
| cmd_wdata | output | DATA_W | Data sent with a write command |
| dq_in | input | DATA_W | Data returned by the bank |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DATA_W | Read data |

## Verification
The end of a wait and the arrival of the next request can fall in the same cycle. In that cycle the pending column command goes out while a request held since the start of the precharge is still waiting. The bench provokes this by sending a second request to the newly opened row directly behind a row miss, so that it is held through the whole precharge and activate wait. The bench then checks that the held request is taken exactly one cycle after the pending column command and is issued as a hit, with no second activate. A second overlap is a read response pulse arriving while later column commands of a burst are still being issued. The bench judges it by matching every pulse to its own read at the T_CL offset.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } dram_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PRE_WAIT = 2'd1,
    ST_ACT_WAIT = 2'd2
  } seq_state_e;

  // Counter preload so that the next command lands t cycles after the current one.
  function automatic int unsigned wait_preload(input int unsigned t);
    return (t == 0) ? 0 : t - 1;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_col_cmd(input dram_cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction
endpackage

// File: rtl/bank_wait_timer.sv
module bank_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic [ROW_W-1:0] set_row,
  input  logic             close,
  input  logic [ROW_W-1:0] probe_row,
  output logic             row_open,
  output logic             row_hit
);
  logic [ROW_W-1:0] open_row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open   <= 1'b0;
      open_row_q <= '0;
    end else if (open_set) begin
      row_open   <= 1'b1;
      open_row_q <= set_row;
    end else if (close) begin
      row_open   <= 1'b0;
    end
  end

  assign row_hit = row_open && (open_row_q == probe_row);

  // R4
  no_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_set |-> !row_open);
endmodule

// File: rtl/bank_rd_pipe.sv
module bank_rd_pipe #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic fire
);
  generate
    if (LAT <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= issue;
      end
      assign fire = stage_q;
    end else begin : g_shift
      logic [LAT-1:0] stage_q;
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[LAT-2:0], issue};
      end
      assign fire = stage_q[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/bank_seq.sv
module bank_seq
  import bank_seq_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 2,
  parameter int T_CL   = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int CNT_W = $clog2(max2(T_RCD, T_RP) + 1);
  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(wait_preload(T_RP));
  localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(wait_preload(T_RCD));

  seq_state_e        state_q;
  dram_cmd_e         cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              pend_wr_q;
  logic [ROW_W-1:0]  pend_row_q;
  logic [COL_W-1:0]  pend_col_q;
  logic [DATA_W-1:0] pend_wdata_q;

  // Named events for the assertions and the sub-blocks
  logic accept, row_open, row_hit, tmr_done;
  logic ev_pre, ev_act, ev_hit, ev_late_col;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [ROW_W-1:0] act_row;

  assign req_ready   = (state_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign ev_hit      = accept && row_hit;
  assign ev_pre      = accept && !row_hit && row_open;
  assign ev_act      = (accept && !row_open) || (state_q == ST_PRE_WAIT && tmr_done);
  assign ev_late_col = (state_q == ST_ACT_WAIT) && tmr_done;
  assign act_row     = (state_q == ST_IDLE) ? req_row : pend_row_q;
  assign tmr_load    = ev_pre || ev_act;
  assign tmr_val     = ev_pre ? RP_LOAD : RCD_LOAD;

  bank_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .open_set(ev_act), .set_row(act_row),
    .close(ev_pre), .probe_row(req_row), .row_open(row_open), .row_hit(row_hit)
  );

  bank_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  bank_rd_pipe #(.LAT(T_CL)) u_rdlat (
    .clk(clk), .rst_n(rst_n), .issue(cmd_q == CMD_RD), .fire(rsp_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cmd_q        <= CMD_NOP;
      addr_q       <= '0;
      wdata_q      <= '0;
      pend_wr_q    <= 1'b0;
      pend_row_q   <= '0;
      pend_col_q   <= '0;
      pend_wdata_q <= '0;
    end else begin
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      wdata_q <= '0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          pend_wr_q    <= req_write;
          pend_row_q   <= req_row;
          pend_col_q   <= req_col;
          pend_wdata_q <= req_wdata;
          if (row_hit) begin
            cmd_q   <= req_write ? CMD_WR : CMD_RD;
            addr_q  <= ADDR_W'(req_col);
            wdata_q <= req_write ? req_wdata : '0;
          end else if (row_open) begin
            cmd_q   <= CMD_PRE;
            state_q <= ST_PRE_WAIT;
          end else begin
            cmd_q   <= CMD_ACT;
            addr_q  <= ADDR_W'(req_row);
            state_q <= ST_ACT_WAIT;
          end
        end
        ST_PRE_WAIT: if (tmr_done) begin
          cmd_q   <= CMD_ACT;
          addr_q  <= ADDR_W'(pend_row_q);
          state_q <= ST_ACT_WAIT;
        end
        ST_ACT_WAIT: if (ev_late_col) begin
          cmd_q   <= pend_wr_q ? CMD_WR : CMD_RD;
          addr_q  <= ADDR_W'(pend_col_q);
          wdata_q <= pend_wr_q ? pend_wdata_q : '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd       = cmd_q;
  assign cmd_addr  = addr_q;
  assign cmd_wdata = wdata_q;
  assign rsp_data  = rsp_valid ? dq_in : '0;

  // R4
  act_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> !$past(row_open));

  // R3
  col_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col_cmd(cmd_q) |-> row_open);

  // R8
  wait_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !is_col_cmd(cmd_q));

  // R5
  idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_NOP || cmd_q == CMD_PRE) |-> (cmd_addr == '0));

  // R7
  wdata_only_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_WR) |-> (cmd_wdata == '0));
endmodule

// File: tb/sim_bank_seq.sv
module sim_bank_seq;
  localparam int RCD = 3, RP = 2, CL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [7:0]  req_row = '0;
  logic [5:0]  req_col = '0;
  logic [15:0] req_wdata = '0, dq_in = '0;
  logic [2:0]  cmd;
  logic [7:0]  cmd_addr;
  logic [15:0] cmd_wdata, rsp_data;
  logic        rsp_valid;

  int nchk = 0, nfail = 0, cyc = 0;
  int lc[64]; int lcmd[64]; int laddr[64]; int lwd[64]; int ln = 0;
  int rc[64]; int rdat[64]; int rn = 0;

  always #4 clk = ~clk;

  bank_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .cmd(cmd), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .dq_in(dq_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (cmd != 3'd0 && ln < 64) begin
      lc[ln] = cyc; lcmd[ln] = int'(cmd); laddr[ln] = int'(cmd_addr); lwd[ln] = int'(cmd_wdata);
      ln++;
    end
    if (rsp_valid && rn < 64) begin
      rc[rn] = cyc; rdat[rn] = int'(rsp_data); rn++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_logs();
    ln = 0; rn = 0;
  endtask

  // Called just after a negedge; returns at the negedge following the accepting edge.
  task automatic send(input bit w, input logic [7:0] row, input logic [5:0] col,
                      input logic [15:0] d, output int acc);
    req_valid = 1'b1; req_write = w; req_row = row; req_col = col; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cmd idle", int'(cmd), 0);
    chk("R1 addr zero", int'(cmd_addr), 0);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_first_read();
    int k;
    clear_logs();
    dq_in = 16'hBEEF;
    send(1'b0, 8'h12, 6'd5, 16'h0, k);
    idle(12);
    chk("R2 cmd count", ln, 2);
    chk("R2 act code", lcmd[0], 1);
    chk("R2 act cycle", lc[0], k);
    chk("R5 act row addr", laddr[0], 8'h12);
    chk("R2 rd code", lcmd[1], 2);
    chk("R2 rd after T_RCD", lc[1], k + RCD);
    chk("R5 rd col addr", laddr[1], 5);
    chk("R6 rsp count", rn, 1);
    chk("R6 rsp cycle", rc[0], k + RCD + CL);
    chk("R6 rsp data", rdat[0], 16'hBEEF);
  endtask

  task automatic t_burst();
    int k1, k2, k3;
    clear_logs();
    dq_in = 16'hA5C3;
    send(1'b0, 8'h12, 6'd6, 16'h0, k1);
    send(1'b1, 8'h12, 6'd7, 16'h1234, k2);
    send(1'b0, 8'h12, 6'd8, 16'h0, k3);
    idle(12);
    chk("R3 back-to-back accept", k2 - k1, 1);
    chk("R3 back-to-back accept 2", k3 - k2, 1);
    chk("R3 cmd count no act", ln, 3);
    chk("R3 rd at accept", lc[0], k1);
    chk("R3 rd code", lcmd[0], 2);
    chk("R3 wr code", lcmd[1], 3);
    chk("R3 wr cycle", lc[1], k2);
    chk("R7 wr data", lwd[1], 16'h1234);
    chk("R7 rd no data", lwd[2], 0);
    chk("R5 wr col addr", laddr[1], 7);
    chk("R6 rsp only for reads", rn, 2);
    chk("R6 rsp 1 cycle", rc[0], k1 + CL);
    chk("R6 rsp 2 cycle", rc[1], k3 + CL);
    chk("R6 rsp data", rdat[1], 16'hA5C3);
  endtask

  task automatic t_miss();
    int k, k2;
    clear_logs();
    send(1'b1, 8'h34, 6'd9, 16'h0F0F, k);
    chk("R8 ready low during wait", int'(req_ready), 0);
    send(1'b0, 8'h34, 6'd10, 16'h0, k2);
    idle(12);
    chk("R4 cmd count", ln, 4);
    chk("R4 pre code", lcmd[0], 4);
    chk("R4 pre cycle", lc[0], k);
    chk("R5 pre addr zero", laddr[0], 0);
    chk("R4 act code", lcmd[1], 1);
    chk("R4 act after T_RP", lc[1], k + RP);
    chk("R5 act new row", laddr[1], 8'h34);
    chk("R4 wr after T_RCD", lc[2], k + RP + RCD);
    chk("R4 wr code", lcmd[2], 3);
    chk("R7 wr data after miss", lwd[2], 16'h0F0F);
    chk("R8 held accept cycle", k2, k + RP + RCD + 1);
    chk("R8 held req is hit", lcmd[3], 2);
    chk("R8 held rd cycle", lc[3], k2);
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_first_read();
    t_burst();
    t_miss();
    summary();
  end
endmodule